// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 peripheral request lines and decides which one the processor should take next. Each source has its own enable flag, pending flag and 2-bit priority level. A rising edge on a request line marks that source pending. Among the sources that are both enabled and pending, the one with the numerically smallest priority value wins. When several share that value, the lowest source number wins. The winner is presented with its vector number (source number plus 16) and its vector-table byte address (vector number times 4).

The block also keeps a record of the handlers that are running. A request is offered only when no handler is running, or when its priority value is strictly smaller than the running one. Requests at the same or a lower level stay pending. When the processor reports that a handler has finished, the previous level is restored and any held request that now qualifies is offered.

The offer to the processor is a valid/ready pair. `req_valid` is recomputed every cycle from the current state. While `req_ready` is low nothing is consumed, and a better request that arrives in the meantime replaces the one shown. A transfer happens in a cycle where both are high: the shown source leaves pending and becomes active. Software reaches the flags and levels through a plain register port. Writes take effect at the clock edge and reads are combinational.

Top module: `pvic_top`

## Requirements
- R1: Writing address 0 sets the enable of every source whose data bit is 1. Zero bits leave the enable unchanged. After reset all enables are 0.
- R2: Writing address 1 clears the enable of every source whose data bit is 1. Reading address 0 or address 1 returns the 32 enable flags, with bit n for source n.
- R3: A 0-to-1 change on `irq_in[n]` sets pending n at the next clock edge. Writing address 2 sets pending bits and writing address 3 clears them (both write-one). Reading address 2 or 3 returns the pending flags. After reset all pending flags are 0.
- R4: Address 4 holds the levels of sources 0 to 15 and address 5 holds sources 16 to 31. The level of source n sits at bits [2k+1:2k] of its word, where k = n mod 16. Both words read back what was written and are 0 after reset.
- R5: Of the sources that are enabled and pending, the one with the smallest level value is offered. On equal levels the lowest source number is offered.
- R6: The offered vector equals the source number plus 16, and the offered address equals the vector times 4 (source 31 gives vector 47 and address 0xBC).
- R7: While a handler runs, `req_valid` is high only for a request whose level value is strictly below `run_prio`. Requests at an equal or larger value stay pending and are not offered.
- R8: In a cycle with `req_valid` and `req_ready` both high, the offered source's pending flag clears. Its active flag sets (read at address 6, bit n). From the next cycle `run_busy` is 1 and `run_prio` equals the accepted level.
- R9: A `hnd_done` pulse ends the innermost running handler: its active flag clears and `run_prio` returns to the level beneath it, or `run_busy` drops to 0. A held request is then offered. `hnd_done` while no handler runs has no effect.
- R10: If `hnd_done` and an accepted transfer fall in the same cycle, the finished handler is removed and the accepted one becomes the innermost, at the accepted level.
- R11: A rising edge on a source's line in the same cycle as that source's transfer leaves its pending flag set, so the new edge is not lost.
- R12: A source whose enable is 0 is never offered, and clearing an enable does not clear the source's pending flag. Once it is enabled again, the held request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Peripheral request lines, edge-detected |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | output | 1 | A request is offered to the processor |
| req_ready | input | 1 | Processor takes the offered request |
| req_irq | output | 5 | Offered source number |
| req_vec | output | 8 | Offered vector number |
| req_vaddr | output | 10 | Offered vector-table byte address |
| req_prio | output | 2 | Level of the offered source |
| hnd_done | input | 1 | Innermost handler has completed |
| run_busy | output | 1 | At least one handler is running |
| run_prio | output | 2 | Level of the innermost running handler |

## Verification
The case of interest is a handler finishing in the same cycle that the processor takes a preempting request. The bench raises a level-0 request by a software pending write while a level-1 handler runs. It then drives `hnd_done` and `req_ready` high together for one cycle. The result is judged by the running level and the active flags: the finished source must drop out of the active set and the accepted one must become innermost. The same-cycle collision of a new line edge with the transfer of that same source is provoked and checked at the pending flag read-back.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int NSRC       = 32;
  localparam int PW         = 2;
  localparam int DW         = 32;
  localparam int AW         = 3;
  localparam int VEC_BASE   = 16;
  localparam int VEC_W      = 8;
  localparam int VADDR_W    = VEC_W + 2;
  localparam int IDW        = $clog2(NSRC);
  localparam int NLVL       = 1 << PW;
  localparam int PER_WORD   = DW / PW;
  localparam int NPW        = (NSRC + PER_WORD - 1) / PER_WORD;
  localparam int PRIO_BASE  = 4;
  localparam int ACT_ADDR   = PRIO_BASE + NPW;

  typedef enum logic [AW-1:0] {
    OP_EN_SET = 3'd0,
    OP_EN_CLR = 3'd1,
    OP_PD_SET = 3'd2,
    OP_PD_CLR = 3'd3
  } cfg_op_e;
endpackage

// File: rtl/pvic_src_bank.sv
module pvic_src_bank #(
  parameter int N   = 32,
  parameter int PW  = 2,
  parameter int DW  = 32,
  parameter int NPW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    edge_set,
  input  logic [N-1:0]    en_set,
  input  logic [N-1:0]    en_clr,
  input  logic [N-1:0]    pd_set,
  input  logic [N-1:0]    pd_clr,
  input  logic [N-1:0]    ack_hot,
  input  logic [N-1:0]    fin_hot,
  input  logic [NPW-1:0]  prio_wsel,
  input  logic [DW-1:0]   wdata,
  output logic [N-1:0]    en_q,
  output logic [N-1:0]    pend_q,
  output logic [N-1:0]    act_q,
  output logic [N*PW-1:0] prio_flat
);
  localparam int PER_WORD = DW / PW;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int WSEL = i / PER_WORD;
    localparam int WOFF = (i % PER_WORD) * PW;
    logic          en_r, pend_r, act_r;
    logic [PW-1:0] prio_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        pend_r <= 1'b0;
        act_r  <= 1'b0;
        prio_r <= '0;
      end else begin
        en_r   <= (en_r | en_set[i]) & ~en_clr[i];
        // hardware edge and software set dominate clears and acknowledge
        pend_r <= (pend_r & ~pd_clr[i] & ~ack_hot[i]) | pd_set[i] | edge_set[i];
        act_r  <= (act_r & ~fin_hot[i]) | ack_hot[i];
        if (prio_wsel[WSEL]) prio_r <= wdata[WOFF +: PW];
      end
    end

    assign en_q[i]              = en_r;
    assign pend_q[i]            = pend_r;
    assign act_q[i]             = act_r;
    assign prio_flat[i*PW +: PW] = prio_r;
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int N   = 32,
  parameter int PW  = 2,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio_flat,
  output logic            hit,
  output logic [IDW-1:0]  win_idx,
  output logic [PW-1:0]   win_prio
);
  // descending scan with <= lets the lower index take ties
  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!hit || prio_flat[i*PW +: PW] <= win_prio)) begin
        hit      = 1'b1;
        win_idx  = IDW'(i);
        win_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack #(
  parameter int DEPTH = 4,
  parameter int IDW   = 5,
  parameter int PW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [IDW-1:0] push_irq,
  input  logic [PW-1:0]  push_prio,
  output logic           top_valid,
  output logic [IDW-1:0] top_irq,
  output logic [PW-1:0]  top_prio
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDW-1:0] irq_mem  [DEPTH];
  logic [PW-1:0]  prio_mem [DEPTH];
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  wptr, tptr;
  logic           do_pop, do_push;

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && (do_pop || cnt < CW'(DEPTH));
  assign wptr    = do_pop ? cnt - CW'(1) : cnt;
  assign tptr    = cnt - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        irq_mem[k]  <= '0;
        prio_mem[k] <= '0;
      end
    end else begin
      if (do_push) begin
        irq_mem[wptr[IW-1:0]]  <= push_irq;
        prio_mem[wptr[IW-1:0]] <= push_prio;
      end
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  assign top_valid = (cnt != '0);
  assign top_irq   = top_valid ? irq_mem[tptr[IW-1:0]]  : '0;
  assign top_prio  = top_valid ? prio_mem[tptr[IW-1:0]] : '0;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_in,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [IDW-1:0]     req_irq,
  output logic [VEC_W-1:0]   req_vec,
  output logic [VADDR_W-1:0] req_vaddr,
  output logic [PW-1:0]      req_prio,
  input  logic               hnd_done,
  output logic               run_busy,
  output logic [PW-1:0]      run_prio
);
  localparam int PADW = NPW * DW;

  logic [NSRC-1:0]    irq_q, edge_set;
  logic [NSRC-1:0]    en_set, en_clr, pd_set, pd_clr;
  logic [NSRC-1:0]    ack_hot, fin_hot;
  logic [NSRC-1:0]    en_q, pend_q, act_q, cand;
  logic [NPW-1:0]     prio_wsel;
  logic [NSRC*PW-1:0] prio_flat;
  logic [PADW-1:0]    prio_pad;
  logic               hit, offer, accept;
  logic [IDW-1:0]     win_idx, top_irq;
  logic [PW-1:0]      win_prio, top_prio;
  logic               top_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end
  assign edge_set = irq_in & ~irq_q;

  assign en_set = (cfg_we && cfg_addr == OP_EN_SET) ? cfg_wdata[NSRC-1:0] : '0;
  assign en_clr = (cfg_we && cfg_addr == OP_EN_CLR) ? cfg_wdata[NSRC-1:0] : '0;
  assign pd_set = (cfg_we && cfg_addr == OP_PD_SET) ? cfg_wdata[NSRC-1:0] : '0;
  assign pd_clr = (cfg_we && cfg_addr == OP_PD_CLR) ? cfg_wdata[NSRC-1:0] : '0;

  for (genvar w = 0; w < NPW; w++) begin : g_wsel
    assign prio_wsel[w] = cfg_we && (cfg_addr == AW'(PRIO_BASE + w));
  end

  pvic_src_bank #(.N(NSRC), .PW(PW), .DW(DW), .NPW(NPW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_set (edge_set),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .pd_set   (pd_set),
    .pd_clr   (pd_clr),
    .ack_hot  (ack_hot),
    .fin_hot  (fin_hot),
    .prio_wsel(prio_wsel),
    .wdata    (cfg_wdata),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .prio_flat(prio_flat)
  );

  assign cand = en_q & pend_q;

  pvic_arbiter #(.N(NSRC), .PW(PW), .IDW(IDW)) u_arb (
    .cand     (cand),
    .prio_flat(prio_flat),
    .hit      (hit),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  // strict preemption: equal level waits for the running handler
  assign offer   = hit && (!top_valid || win_prio < top_prio);
  assign accept  = offer && req_ready;
  assign ack_hot = accept ? (NSRC'(1) << win_idx) : '0;
  assign fin_hot = (hnd_done && top_valid) ? (NSRC'(1) << top_irq) : '0;

  pvic_level_stack #(.DEPTH(NLVL), .IDW(IDW), .PW(PW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .pop      (hnd_done),
    .push_irq (win_idx),
    .push_prio(win_prio),
    .top_valid(top_valid),
    .top_irq  (top_irq),
    .top_prio (top_prio)
  );

  assign req_valid = offer;
  assign req_irq   = win_idx;
  assign req_prio  = win_prio;
  assign req_vec   = VEC_W'(win_idx) + VEC_W'(VEC_BASE);
  assign req_vaddr = {req_vec, 2'b00};
  assign run_busy  = top_valid;
  assign run_prio  = top_prio;

  assign prio_pad = PADW'(prio_flat);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OP_EN_SET || cfg_addr == OP_EN_CLR) cfg_rdata = DW'(en_q);
    if (cfg_addr == OP_PD_SET || cfg_addr == OP_PD_CLR) cfg_rdata = DW'(pend_q);
    if (cfg_addr == AW'(ACT_ADDR))                      cfg_rdata = DW'(act_q);
    for (int w = 0; w < NPW; w++) begin
      if (cfg_addr == AW'(PRIO_BASE + w)) cfg_rdata = prio_pad[w*DW +: DW];
    end
  end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
  import pvic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IDW-1:0]     req_irq,
  input logic [VEC_W-1:0]   req_vec,
  input logic [VADDR_W-1:0] req_vaddr,
  input logic [PW-1:0]      req_prio,
  input logic               hnd_done,
  input logic               run_busy,
  input logic [PW-1:0]      run_prio,
  input logic [NSRC-1:0]    en_q,
  input logic [NSRC-1:0]    pend_q
);
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && run_busy) |-> (req_prio < run_prio)); // R7

  AST_OFFER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (en_q[req_irq] && pend_q[req_irq])); // R5

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vec >= VEC_W'(VEC_BASE) && req_vec < VEC_W'(VEC_BASE + NSRC)
                   && req_vaddr[1:0] == 2'b00)); // R6

  AST_ACCEPT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (run_busy && run_prio == $past(req_prio))); // R8

  AST_DONE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_done && run_busy && !(req_valid && req_ready))
      |=> (!run_busy || run_prio > $past(run_prio))); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !(req_valid && req_ready)) |=> !run_busy); // R9
endmodule

bind pvic_top pvic_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_irq  (req_irq),
  .req_vec  (req_vec),
  .req_vaddr(req_vaddr),
  .req_prio (req_prio),
  .hnd_done (hnd_done),
  .run_busy (run_busy),
  .run_prio (run_prio),
  .en_q     (en_q),
  .pend_q   (pend_q)
);

// File: tb/pvic_top_test.sv
module pvic_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid, req_ready;
  logic [4:0]  req_irq;
  logic [7:0]  req_vec;
  logic [9:0]  req_vaddr;
  logic [1:0]  req_prio;
  logic        hnd_done, run_busy;
  logic [1:0]  run_prio;

  int total = 0;
  int bad   = 0;

  typedef struct { int irq; int prio; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pvic_top uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_irq(req_irq),
    .req_vec(req_vec), .req_vaddr(req_vaddr), .req_prio(req_prio),
    .hnd_done(hnd_done), .run_busy(run_busy), .run_prio(run_prio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic expect_take(input int irq, input int prio);
    exp_t e;
    e.irq = irq; e.prio = prio;
    sb_q.push_back(e);
  endtask

  task automatic take();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic finish_hnd();
    hnd_done = 1'b1;
    @(negedge clk);
    hnd_done = 1'b0;
  endtask

  task automatic raise(input logic [31:0] m);
    irq_in = irq_in | m;
    @(negedge clk);
  endtask

  // monitor: every transfer must match the next scoreboard entry (R5 R6 R8)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && req_valid && req_ready) begin
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R5 actual=unexpected transfer irq %0d expected=none", req_irq);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R5 transfer irq", 32'(req_irq), 32'(e.irq));
          chk("R5 transfer level", 32'(req_prio), 32'(e.prio));
          chk("R6 transfer vector", 32'(req_vec), 32'(e.irq + 16));
          chk("R6 transfer address", 32'(req_vaddr), 32'((e.irq + 16) * 4));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_ready = 1'b0; hnd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd0, d); chk("R1 reset enables", d, 32'h0);
    rd(3'd2, d); chk("R3 reset pending", d, 32'h0);
    rd(3'd4, d); chk("R4 reset levels", d, 32'h0);
    chk("R8 reset idle", {30'd0, req_valid, run_busy}, 32'h0);

    // enable set/clear registers
    wr(3'd0, 32'h8000_0005);
    rd(3'd0, d); chk("R1 set enables", d, 32'h8000_0005);
    rd(3'd1, d); chk("R2 read via clear address", d, 32'h8000_0005);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R1 zero bits no effect", d, 32'h8000_0005);
    wr(3'd1, 32'h1);
    rd(3'd1, d); chk("R2 clear enable", d, 32'h8000_0004);
    wr(3'd0, 32'hFFFF_FFFF);

    // levels: all 3, irq2=2, irq5=1, irq9=1, irq31=0
    wr(3'd4, 32'hFFF7_F7EF);
    wr(3'd5, 32'h3FFF_FFFF);
    rd(3'd4, d); chk("R4 level word 0", d, 32'hFFF7_F7EF);
    rd(3'd5, d); chk("R4 level word 1", d, 32'h3FFF_FFFF);

    // disabled source holds pending, not offered
    wr(3'd1, 32'h80);
    raise(32'h80);
    rd(3'd2, d); chk("R3 edge sets pending", d, 32'h80);
    chk("R12 disabled not offered", {31'd0, req_valid}, 32'h0);
    wr(3'd3, 32'h80);
    rd(3'd3, d); chk("R3 software clear pending", d, 32'h0);
    wr(3'd0, 32'h80);

    // tie at level 1: irq5 beats irq9
    raise(32'h220);
    chk("R5 tie offered", {26'd0, req_valid, req_irq}, {26'd0, 1'b1, 5'd5});
    expect_take(5, 1);
    take();
    chk("R8 running level", {29'd0, run_busy, run_prio}, {29'd0, 1'b1, 2'd1});
    rd(3'd6, d); chk("R8 active flag", d, 32'h20);
    rd(3'd2, d); chk("R8 pending cleared", d, 32'h200);
    chk("R7 equal level held", {31'd0, req_valid}, 32'h0);

    raise(32'h8);
    chk("R7 lower level held", {31'd0, req_valid}, 32'h0);
    raise(32'h8000_0000);
    chk("R6 irq31 vector", {24'd0, req_vec}, 32'd47);
    chk("R6 irq31 address", {22'd0, req_vaddr}, 32'hBC);
    expect_take(31, 0);
    take();
    chk("R8 nested level", {30'd0, run_prio}, 32'd0);

    finish_hnd();
    chk("R9 level restored", {29'd0, run_busy, run_prio}, {29'd0, 1'b1, 2'd1});
    chk("R9 held stays held", {31'd0, req_valid}, 32'h0);

    // completion and transfer in the same cycle
    wr(3'd2, 32'h8000_0000);
    chk("R10 preempt offered", {31'd0, req_valid}, 32'h1);
    expect_take(31, 0);
    req_ready = 1'b1; hnd_done = 1'b1;
    @(negedge clk);
    req_ready = 1'b0; hnd_done = 1'b0;
    chk("R10 new innermost level", {29'd0, run_busy, run_prio}, {29'd0, 1'b1, 2'd0});
    rd(3'd6, d); chk("R10 active set", d, 32'h8000_0000);

    finish_hnd();
    chk("R9 idle after last", {31'd0, run_busy}, 32'h0);
    chk("R9 held request offered", {26'd0, req_valid, req_irq}, {26'd0, 1'b1, 5'd9});
    expect_take(9, 1);
    take();
    finish_hnd();
    expect_take(3, 3);
    take();
    finish_hnd();
    chk("R9 drained", {30'd0, req_valid, run_busy}, 32'h0);
    finish_hnd();
    chk("R9 done while idle ignored", {29'd0, run_busy, run_prio}, 32'h0);

    // edge in the same cycle as the transfer of that source
    raise(32'h4);
    irq_in[2] = 1'b0;
    @(negedge clk);
    irq_in[2] = 1'b1;
    expect_take(2, 2);
    take();
    rd(3'd2, d); chk("R11 pending kept", d, 32'h4);
    rd(3'd6, d); chk("R11 source active", d, 32'h4);
    finish_hnd();
    expect_take(2, 2);
    take();
    finish_hnd();
    rd(3'd2, d); chk("R11 second request served", d, 32'h0);

    // disabling keeps pending; re-enable offers it
    wr(3'd1, 32'h10);
    wr(3'd2, 32'h10);
    chk("R12 not offered while disabled", {31'd0, req_valid}, 32'h0);
    rd(3'd2, d); chk("R12 pending kept", d, 32'h10);
    wr(3'd0, 32'h10);
    chk("R12 offered after enable", {26'd0, req_valid, req_irq}, {26'd0, 1'b1, 5'd4});
    expect_take(4, 3);
    take();
    finish_hnd();

    repeat (2) @(negedge clk);
    chk("R8 all transfers seen", 32'(sb_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule